// File: doc/BRIEF.md
# Compressed branch decode unit

This unit takes one 16-bit compressed instruction and works out everything a fetch stage needs for it if it is a branch. It handles three branch forms: the PC-relative jump with an optional link, the PC-relative conditional branch, and the return through the link register. It works in both the short (10-bit) encoding mode and the full 16-bit encoding mode. The unit selects the condition bit from an 8-bit slice that holds the first two condition fields. From that bit it decides whether the branch is taken. It forms the target either from the current PC or from the link register, and it reports whether the link register must be written and with what value. It also flags encodings that are illegal.

Bits are numbered from the most significant end: instruction bit 0 is `hw_i[15]` and instruction bit 15 is `hw_i[0]`. Bit 0 is the N flag, bits 1-4 are the extension field, bits 5-7 are the major opcode, bit 8 is the minor opcode, bits 9-14 are the body and bit 15 is the M flag. The results are registered. An instruction presented in one cycle has its result on the outputs after the next rising edge. Counter decrement and pipeline redirection are left to the surrounding logic.

Top module: `cbr_unit`

## Requirements
- R1: While `rst_ni` is low, every output is zero.
- R2: The outputs show the result for the inputs seen at the previous rising edge. A jump has major.minor `000.L` with body `hw_i[6:1]` nonzero. In 10-bit mode (`wide_i`=0) its offset is the body taken as a 6-bit signed value. The branch is taken and `target_o` = PC + 2*offset.
- R3: In 16-bit mode a jump that is not conditional (see R5) uses the 10-bit signed offset {`hw_i[14:11]`, `hw_i[6:1]`}.
- R4: A legal branch with its link flag set raises `link_we_o` whether or not it is taken, and `link_addr_o` = PC + 2. The link flag is `hw_i[7]` for jumps and conditional branches, and `hw_i[6]` for returns. Otherwise `link_addr_o` is zero.
- R5: In 16-bit mode, major 000 with N=`hw_i[15]`=1 and M=`hw_i[0]`=1 is a conditional branch. Its CR index is `hw_i[6:4]` and its invert bit is `hw_i[3]`. Its 6-bit signed offset is {`hw_i[14:11]`, `hw_i[2:1]`}. It is taken when `cr_i[index]` XOR invert is 1. `target_o` is PC + 2*offset whether or not it is taken.
- R6: In 10-bit mode the conditional form does not exist. Major 000 with M=1 and a nonzero body is a plain jump, and bits 0-4 are ignored.
- R7: A major-000 word that is not conditional and has a zero body raises `illegal_o` when the link flag and M are both 0, and, in 16-bit mode, `hw_i[15:11]` is also zero. Any other zero-body word gives no branch, no link and no illegal flag.
- R8: Major.minor `001.0` is a return. Its target is `lr_i` with bit 0 cleared. `hw_i[3]` enables the CR test and `hw_i[2]` inverts it. With the test disabled, the return is always taken.
- R9: For a return, the CR index is `hw_i[5:4]` in 10-bit mode, which reaches CR0 only. In 16-bit mode the index is {`hw_i[13:11]`, `hw_i[5:4]`}, and an index of 8 or more raises `illegal_o`.
- R10: A return with the counter option `hw_i[1]` set is illegal in both modes. A return with the 16-bit option bit `hw_i[14]` set is illegal in 16-bit mode only.
- R11: Every other major.minor value gives all outputs zero.
- R12: Target and link sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_i | input | 16 | Compressed instruction halfword |
| wide_i | input | 1 | 1 selects 16-bit mode, 0 selects 10-bit mode |
| pc_i | input | 64 | Address of the halfword |
| cr_i | input | 8 | CR0 in bits 3:0, CR1 in bits 7:4 |
| lr_i | input | 64 | Link register value |
| taken_o | output | 1 | Branch is taken |
| target_o | output | 64 | Branch target; zero when the word is not a branch |
| link_we_o | output | 1 | Link register must be written |
| link_addr_o | output | 64 | Value to write to the link register |
| illegal_o | output | 1 | Illegal encoding |

## Verification
Every result is due exactly one rising edge after its instruction is presented, because a single register stage lies between the inputs and the outputs. The bench drives each instruction on a falling edge and samples all five outputs on the next falling edge, half a period after the capturing edge. Each case is therefore read in the only cycle it is valid, and no case depends on the order of events at the clock edge. The properties use `$past` of the PC one cycle back to tie the link value and target alignment to that same one-cycle latency.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int HW_W   = 16;
    localparam int OFFS_W = 10;
    localparam int BI_W   = 5;

    typedef enum logic [2:0] {
        BR_NONE,
        BR_JUMP,
        BR_COND,
        BR_TOLR,
        BR_ILLEG
    } br_kind_e;

    typedef struct packed {
        br_kind_e            kind;
        logic                lk;
        logic [OFFS_W-1:0]   offs;
        logic [BI_W-1:0]     bi;
        logic                test_en;
        logic                test_inv;
    } br_dec_t;

endpackage

// File: rtl/cbr_field_decode.sv
module cbr_field_decode
    import cbr_pkg::*;
(
    input  logic [HW_W-1:0] hw_i,
    input  logic            wide_i,
    output br_dec_t         dec_o
);

    localparam int N_POS  = HW_W - 1;
    localparam int M_POS  = 0;
    localparam int MIN_POS = 7;

    logic       n_bit;
    logic       m_bit;
    logic       minor;
    logic [2:0] major;
    logic [3:0] ext4;
    logic [5:0] body6;
    logic       front_zero;

    assign n_bit      = hw_i[N_POS];
    assign m_bit      = hw_i[M_POS];
    assign minor      = hw_i[MIN_POS];
    assign major      = hw_i[10:8];
    assign ext4       = hw_i[14:11];
    assign body6      = hw_i[6:1];
    assign front_zero = (hw_i[15:11] == 5'd0);

    always_comb begin
        dec_o      = '0;
        dec_o.kind = BR_NONE;
        if (major == 3'b000) begin
            if (wide_i && n_bit && m_bit) begin
                // conditional: offset = ext4 || oo, index in body high bits
                dec_o.kind     = BR_COND;
                dec_o.lk       = minor;
                dec_o.offs     = {{(OFFS_W-6){ext4[3]}}, ext4, hw_i[2:1]};
                dec_o.bi       = {{(BI_W-3){1'b0}}, hw_i[6:4]};
                dec_o.test_en  = 1'b1;
                dec_o.test_inv = hw_i[3];
            end else if (body6 != 6'd0) begin
                dec_o.kind = BR_JUMP;
                dec_o.lk   = minor;
                if (wide_i) begin
                    dec_o.offs = {ext4, body6};
                end else begin
                    dec_o.offs = {{(OFFS_W-6){body6[5]}}, body6};
                end
            end else if (!minor && !m_bit && (!wide_i || front_zero)) begin
                dec_o.kind = BR_ILLEG;
            end
        end else if (major == 3'b001 && !minor) begin
            if (hw_i[1] || (wide_i && hw_i[14])) begin
                dec_o.kind = BR_ILLEG;
            end else begin
                dec_o.kind     = BR_TOLR;
                dec_o.lk       = hw_i[6];
                dec_o.test_en  = hw_i[3];
                dec_o.test_inv = hw_i[2];
                if (wide_i) begin
                    dec_o.bi = {hw_i[13:11], hw_i[5:4]};
                end else begin
                    dec_o.bi = {{(BI_W-2){1'b0}}, hw_i[5:4]};
                end
            end
        end
    end

endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
    import cbr_pkg::*;
#(
    parameter int CR_BITS = 8
) (
    input  logic [BI_W-1:0]    bi_i,
    input  logic               test_en_i,
    input  logic               test_inv_i,
    input  logic [CR_BITS-1:0] cr_i,
    output logic               pass_o,
    output logic               bi_oob_o
);

    logic sel_bit;

    always_comb begin
        sel_bit = 1'b0;
        for (int k = 0; k < CR_BITS; k++) begin
            if (int'(bi_i) == k) begin
                sel_bit = cr_i[k];
            end
        end
        bi_oob_o = (int'(bi_i) >= CR_BITS);
        pass_o   = !test_en_i || (sel_bit ^ test_inv_i);
    end

endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen #(
    parameter int XLEN   = 64,
    parameter int OFFS_W = 10
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   lr_i,
    input  logic [OFFS_W-1:0] offs_i,
    output logic [XLEN-1:0]   rel_o,
    output logic [XLEN-1:0]   ret_o,
    output logic [XLEN-1:0]   next_o
);

    localparam int EXT_W = XLEN - OFFS_W - 1;

    logic [XLEN-1:0] disp;

    assign disp   = {{EXT_W{offs_i[OFFS_W-1]}}, offs_i, 1'b0};
    assign rel_o  = pc_i + disp;
    assign next_o = pc_i + XLEN'(2);
    assign ret_o  = lr_i & ~XLEN'(1);

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
    import cbr_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CR_BITS = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [15:0]        hw_i,
    input  logic               wide_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [CR_BITS-1:0] cr_i,
    input  logic [XLEN-1:0]    lr_i,
    output logic               taken_o,
    output logic [XLEN-1:0]    target_o,
    output logic               link_we_o,
    output logic [XLEN-1:0]    link_addr_o,
    output logic               illegal_o
);

    typedef struct packed {
        logic            taken;
        logic            link_we;
        logic            illegal;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] link;
    } res_t;

    br_dec_t         dec;
    logic            pass;
    logic            bi_oob;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] ret_tgt;
    logic [XLEN-1:0] next_pc;
    res_t            res_d;
    res_t            res_q;

    cbr_field_decode u_decode (
        .hw_i   (hw_i),
        .wide_i (wide_i),
        .dec_o  (dec)
    );

    cbr_cond_eval #(
        .CR_BITS (CR_BITS)
    ) u_cond (
        .bi_i       (dec.bi),
        .test_en_i  (dec.test_en),
        .test_inv_i (dec.test_inv),
        .cr_i       (cr_i),
        .pass_o     (pass),
        .bi_oob_o   (bi_oob)
    );

    cbr_target_gen #(
        .XLEN   (XLEN),
        .OFFS_W (OFFS_W)
    ) u_target (
        .pc_i   (pc_i),
        .lr_i   (lr_i),
        .offs_i (dec.offs),
        .rel_o  (rel_tgt),
        .ret_o  (ret_tgt),
        .next_o (next_pc)
    );

    always_comb begin
        res_d = '0;
        case (dec.kind)
            BR_JUMP: begin
                res_d.taken   = 1'b1;
                res_d.target  = rel_tgt;
                res_d.link_we = dec.lk;
            end
            BR_COND: begin
                res_d.taken   = pass;
                res_d.target  = rel_tgt;
                res_d.link_we = dec.lk;
            end
            BR_TOLR: begin
                if (bi_oob) begin
                    res_d.illegal = 1'b1;
                end else begin
                    res_d.taken   = pass;
                    res_d.target  = ret_tgt;
                    res_d.link_we = dec.lk;
                end
            end
            BR_ILLEG: begin
                res_d.illegal = 1'b1;
            end
            default: begin
            end
        endcase
        if (res_d.link_we) begin
            res_d.link = next_pc;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign taken_o     = res_q.taken;
    assign target_o    = res_q.target;
    assign link_we_o   = res_q.link_we;
    assign link_addr_o = res_q.link;
    assign illegal_o   = res_q.illegal;

endmodule

// File: rtl/cbr_unit_chk.sv
module cbr_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [1:0]      major_hi_i,
    input logic [XLEN-1:0] pc_i,
    input logic            taken_o,
    input logic            tgt_lsb_i,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_addr_o,
    input logic            illegal_o
);

    assert_illegal_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (!taken_o && !link_we_o));

    assert_link_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_we_o |-> (link_addr_o == $past(pc_i) + XLEN'(2)));

    assert_link_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !link_we_o |-> (link_addr_o == '0));

    assert_target_even_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_o && !$past(pc_i[0])) |-> !tgt_lsb_i);

    assert_other_major_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(major_hi_i) != 2'b00) |-> (!taken_o && !link_we_o && !illegal_o));

endmodule

bind cbr_unit cbr_unit_chk #(
    .XLEN (XLEN)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .major_hi_i  (hw_i[10:9]),
    .pc_i        (pc_i),
    .taken_o     (taken_o),
    .tgt_lsb_i   (target_o[0]),
    .link_we_o   (link_we_o),
    .link_addr_o (link_addr_o),
    .illegal_o   (illegal_o)
);

// File: tb/cbr_unit_tb.sv
module cbr_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [15:0] hw;
    logic        wide;
    logic [63:0] pc;
    logic [7:0]  cr;
    logic [63:0] lr;
    logic        taken;
    logic [63:0] target;
    logic        link_we;
    logic [63:0] link_addr;
    logic        illegal;

    int total = 0;
    int bad   = 0;

    cbr_unit u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hw_i        (hw),
        .wide_i      (wide),
        .pc_i        (pc),
        .cr_i        (cr),
        .lr_i        (lr),
        .taken_o     (taken),
        .target_o    (target),
        .link_we_o   (link_we),
        .link_addr_o (link_addr),
        .illegal_o   (illegal)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] enc_jump(logic n, logic [3:0] x, logic lk,
                                             logic [5:0] body, logic m);
        return {n, x, 3'b000, lk, body, m};
    endfunction

    function automatic logic [15:0] enc_cond(logic [3:0] x, logic lk, logic [2:0] bi,
                                             logic inv, logic [1:0] oo);
        return {1'b1, x, 3'b000, lk, bi, inv, oo, 1'b1};
    endfunction

    function automatic logic [15:0] enc_ret(logic bo3, logic [2:0] bi3, logic lk,
                                            logic [1:0] bil, logic en, logic inv, logic ctr);
        return {1'b0, bo3, bi3, 3'b001, 1'b0, lk, bil, en, inv, ctr, 1'b0};
    endfunction

    function automatic logic [63:0] rel(logic [63:0] base, longint units);
        return base + 64'(units * 2);
    endfunction

    task automatic issue(logic [15:0] h, logic w, logic [63:0] p, logic [7:0] c, logic [63:0] l);
        hw   = h;
        wide = w;
        pc   = p;
        cr   = c;
        lr   = l;
        @(negedge clk);
    endtask

    task automatic expect_out(string tag, logic e_taken, logic [63:0] e_tgt,
                              logic e_lwe, logic [63:0] e_link, logic e_ill);
        total++;
        if (taken !== e_taken || target !== e_tgt || link_we !== e_lwe ||
            link_addr !== e_link || illegal !== e_ill) begin
            bad++;
            $display("FAIL %s: got taken=%0b target=%h link_we=%0b link=%h illegal=%0b, expected taken=%0b target=%h link_we=%0b link=%h illegal=%0b",
                     tag, taken, target, link_we, link_addr, illegal,
                     e_taken, e_tgt, e_lwe, e_link, e_ill);
        end
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 1'b0, 64'd0, 1'b0, 64'd0, 1'b0);
    endtask

    task automatic t_jump_short();
        issue(enc_jump(1'b0, 4'd0, 1'b0, 6'd3, 1'b0), 1'b0, 64'h1000, 8'h00, 64'h0);
        expect_out("R2 short jump +3", 1'b1, rel(64'h1000, 3), 1'b0, 64'd0, 1'b0);
        issue(enc_jump(1'b0, 4'd0, 1'b0, 6'h20, 1'b0), 1'b0, 64'h4000, 8'hFF, 64'h0);
        expect_out("R2 short jump -32", 1'b1, rel(64'h4000, -32), 1'b0, 64'd0, 1'b0);
    endtask

    task automatic t_link();
        issue(enc_jump(1'b0, 4'd0, 1'b1, 6'h3F, 1'b0), 1'b0, 64'h2000, 8'h00, 64'h0);
        expect_out("R4 jump with link", 1'b1, rel(64'h2000, -1), 1'b1, 64'h2002, 1'b0);
    endtask

    task automatic t_jump_long();
        issue(enc_jump(1'b0, 4'b1000, 1'b0, 6'd1, 1'b0), 1'b1, 64'h10000, 8'h00, 64'h0);
        expect_out("R3 long jump -511", 1'b1, rel(64'h10000, -511), 1'b0, 64'd0, 1'b0);
        issue(enc_jump(1'b0, 4'b0001, 1'b0, 6'd5, 1'b1), 1'b1, 64'h300, 8'h00, 64'h0);
        expect_out("R3 long jump +69", 1'b1, rel(64'h300, 69), 1'b0, 64'd0, 1'b0);
    endtask

    task automatic t_no_cond_short();
        issue(enc_jump(1'b1, 4'b1111, 1'b0, 6'd2, 1'b1), 1'b0, 64'h800, 8'h00, 64'h0);
        expect_out("R6 no conditional in 10-bit mode", 1'b1, rel(64'h800, 2), 1'b0, 64'd0, 1'b0);
    endtask

    task automatic t_cond();
        issue(enc_cond(4'b0000, 1'b0, 3'd5, 1'b0, 2'd2), 1'b1, 64'h500, 8'h20, 64'h0);
        expect_out("R5 cond taken", 1'b1, rel(64'h500, 2), 1'b0, 64'd0, 1'b0);
        issue(enc_cond(4'b0000, 1'b0, 3'd5, 1'b1, 2'd2), 1'b1, 64'h500, 8'h20, 64'h0);
        expect_out("R5 cond inverted not taken", 1'b0, rel(64'h500, 2), 1'b0, 64'd0, 1'b0);
        issue(enc_cond(4'b1111, 1'b0, 3'd0, 1'b1, 2'b10), 1'b1, 64'h600, 8'hFE, 64'h0);
        expect_out("R5 cond inverted taken backward", 1'b1, rel(64'h600, -2), 1'b0, 64'd0, 1'b0);
        issue(enc_cond(4'b0000, 1'b0, 3'd0, 1'b0, 2'b00), 1'b1, 64'h700, 8'h01, 64'h0);
        expect_out("R5 cond all-zero fields is a branch", 1'b1, 64'h700, 1'b0, 64'd0, 1'b0);
        issue(enc_cond(4'b0000, 1'b1, 3'd7, 1'b0, 2'd1), 1'b1, 64'h900, 8'h00, 64'h0);
        expect_out("R4 cond link while not taken", 1'b0, rel(64'h900, 1), 1'b1, 64'h902, 1'b0);
    endtask

    task automatic t_zero_offset();
        issue(16'h0000, 1'b1, 64'h100, 8'h00, 64'h0);
        expect_out("R7 all-zero 16-bit illegal", 1'b0, 64'd0, 1'b0, 64'd0, 1'b1);
        issue(16'hF800, 1'b0, 64'h100, 8'h00, 64'h0);
        expect_out("R7 zero word 10-bit illegal", 1'b0, 64'd0, 1'b0, 64'd0, 1'b1);
        issue(enc_jump(1'b0, 4'd0, 1'b1, 6'd0, 1'b0), 1'b1, 64'h100, 8'h00, 64'h0);
        expect_out("R7 zero body with link is no branch", 1'b0, 64'd0, 1'b0, 64'd0, 1'b0);
        issue(enc_jump(1'b1, 4'd0, 1'b0, 6'd0, 1'b0), 1'b1, 64'h100, 8'h00, 64'h0);
        expect_out("R7 N=1 zero body no branch", 1'b0, 64'd0, 1'b0, 64'd0, 1'b0);
        issue(enc_jump(1'b0, 4'b0100, 1'b0, 6'd0, 1'b0), 1'b1, 64'h100, 8'h00, 64'h0);
        expect_out("R7 nonzero extension not illegal", 1'b0, 64'd0, 1'b0, 64'd0, 1'b0);
        issue(enc_jump(1'b0, 4'd0, 1'b0, 6'd0, 1'b1), 1'b0, 64'h100, 8'h00, 64'h0);
        expect_out("R7 M=1 zero body no branch", 1'b0, 64'd0, 1'b0, 64'd0, 1'b0);
    endtask

    task automatic t_ret();
        issue(enc_ret(1'b0, 3'd0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0), 1'b0, 64'h40, 8'h04, 64'h0000_1234_5678_ABCD);
        expect_out("R8 return taken", 1'b1, 64'h0000_1234_5678_ABCC, 1'b0, 64'd0, 1'b0);
        issue(enc_ret(1'b0, 3'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0), 1'b0, 64'h40, 8'h04, 64'h0000_1234_5678_ABCD);
        expect_out("R8 return inverted not taken", 1'b0, 64'h0000_1234_5678_ABCC, 1'b0, 64'd0, 1'b0);
        issue(enc_ret(1'b0, 3'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0), 1'b0, 64'h80, 8'h00, 64'h0000_0000_0000_2000);
        expect_out("R8 return untested with link", 1'b1, 64'h2000, 1'b1, 64'h82, 1'b0);
    endtask

    task automatic t_ret_wide();
        issue(enc_ret(1'b0, 3'b001, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0), 1'b1, 64'h40, 8'h20, 64'h3000);
        expect_out("R9 wide index reaches CR1", 1'b1, 64'h3000, 1'b0, 64'd0, 1'b0);
        issue(enc_ret(1'b0, 3'b001, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0), 1'b1, 64'h40, 8'h02, 64'h3000);
        expect_out("R9 wide index not CR0 bit", 1'b0, 64'h3000, 1'b0, 64'd0, 1'b0);
        issue(enc_ret(1'b0, 3'b001, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0), 1'b0, 64'h40, 8'h02, 64'h3000);
        expect_out("R9 short index CR0 only", 1'b1, 64'h3000, 1'b0, 64'd0, 1'b0);
        issue(enc_ret(1'b0, 3'b010, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0), 1'b1, 64'h40, 8'hFF, 64'h3000);
        expect_out("R9 index beyond CR1 illegal", 1'b0, 64'd0, 1'b0, 64'd0, 1'b1);
    endtask

    task automatic t_ret_options();
        issue(enc_ret(1'b0, 3'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1), 1'b0, 64'h40, 8'h00, 64'h3000);
        expect_out("R10 counter option illegal 10-bit", 1'b0, 64'd0, 1'b0, 64'd0, 1'b1);
        issue(enc_ret(1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1), 1'b1, 64'h40, 8'h00, 64'h3000);
        expect_out("R10 counter option illegal 16-bit", 1'b0, 64'd0, 1'b0, 64'd0, 1'b1);
        issue(enc_ret(1'b1, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0), 1'b1, 64'h40, 8'h00, 64'h3000);
        expect_out("R10 wide option bit illegal", 1'b0, 64'd0, 1'b0, 64'd0, 1'b1);
        issue(enc_ret(1'b1, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0), 1'b0, 64'h40, 8'h00, 64'h3000);
        expect_out("R10 option bit ignored in 10-bit", 1'b1, 64'h3000, 1'b0, 64'd0, 1'b0);
    endtask

    task automatic t_other();
        issue({1'b0, 4'd0, 3'b010, 1'b1, 6'd3, 1'b0}, 1'b1, 64'h40, 8'hFF, 64'h3000);
        expect_out("R11 major 010 quiet", 1'b0, 64'd0, 1'b0, 64'd0, 1'b0);
        issue({1'b0, 4'd0, 3'b001, 1'b1, 6'h3F, 1'b0}, 1'b0, 64'h40, 8'hFF, 64'h3000);
        expect_out("R11 major 001 minor 1 quiet", 1'b0, 64'd0, 1'b0, 64'd0, 1'b0);
        issue(16'hFFFF, 1'b1, 64'h40, 8'hFF, 64'h3000);
        expect_out("R11 major 111 quiet", 1'b0, 64'd0, 1'b0, 64'd0, 1'b0);
    endtask

    task automatic t_wrap();
        issue(enc_jump(1'b0, 4'd0, 1'b1, 6'd2, 1'b0), 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 8'h00, 64'h0);
        expect_out("R12 wrap forward", 1'b1, 64'h2, 1'b1, 64'h0, 1'b0);
        issue(enc_jump(1'b0, 4'd0, 1'b0, 6'h3E, 1'b0), 1'b0, 64'h2, 8'h00, 64'h0);
        expect_out("R12 wrap backward", 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 64'd0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        hw    = 16'h0;
        wide  = 1'b0;
        pc    = 64'h0;
        cr    = 8'h0;
        lr    = 64'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_jump_short();
        t_link();
        t_jump_long();
        t_no_cond_short();
        t_cond();
        t_zero_offset();
        t_ret();
        t_ret_wide();
        t_ret_options();
        t_other();
        t_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule